// File: doc/BRIEF.md
# USB Line-State and Speed Tracker

This block watches the two data wires of a low-speed/full-speed USB bus from a fast system clock. After bringing both wires into the clock domain, it names the present line condition as one of four symbols: J, K, SE0 or SE1. It also keeps track of which signalling mode the bus is in.

There are three modes:

- full-speed;
- low-speed, in which J and K are swapped;
- low-speed bit rate with full-speed polarity, entered after a preamble.

Each SE0 interval is timed. When the bus leaves SE0, the block reports one of two events:

- a bus reset, if the SE0 was long;
- a low-speed keep-alive, if the SE0 was of medium length and the block is in low-speed mode.

A speed-select input chooses between automatic learning and a forced full-speed or low-speed mode. Downstream bit recovery uses the symbol and speed outputs.

The outputs are continuous line state, not a data stream. There is therefore no valid/ready handshake. The symbol is always valid, and the two event outputs are single-cycle strobes that cannot be held off. The SE0 limits are computed from the clock-frequency parameter at elaboration.

Top module: `usb_line_tracker`

## Requirements
- R1: In full-speed mode and in preamble mode, wires {D+,D-}=10 decode to J and 01 decode to K. The symbol codes are J=0, K=1, SE0=2, SE1=3.
- R2: In low-speed mode, the J/K assignment is swapped: 01 is J and 10 is K.
- R3: Wires 00 always decode to SE0 and 11 always decode to SE1, whatever the mode.
- R4: Both wires pass through two synchronizing flops, so the symbol reflects the wire values from two clock edges earlier. Until two edges have passed after tracker reset, the symbol is J and no SE0 is timed.
- R5: With speed-select automatic (codes 0 and 3), leaving SE0 into 10 selects full-speed and leaving into 01 selects low-speed. Leaving into 11 keeps the mode.
- R6: With speed-select full-speed (1) or low-speed (2), the idle level after SE0 does not change the mode. The mode changes only through a bus reset, a preamble or a tracker reset.
- R7: An SE0 lasting more than RESET_NS gives a single-cycle pulse on bus_reset_o during the first cycle the synchronized wires are no longer SE0. At that point the mode returns to the speed-select setting, with automatic starting from full-speed and then learning from the idle level.
- R8: An SE0 lasting more than KEEPALIVE_NS but not more than RESET_NS gives a single-cycle pulse on keep_alive_o during the exit cycle. This happens only in low-speed mode, never in full-speed or preamble mode, and never together with bus_reset_o.
- R9: An SE0 not longer than KEEPALIVE_NS produces neither pulse.
- R10: A high preamble_i sets preamble mode at the next edge: speed_o=2, ls_rate_o=1, fs_pol_o=1. If an SE0 exit falls on the same edge, the exit rule wins.
- R11: speed_o uses codes 0 for full-speed, 1 for low-speed and 2 for preamble mode. ls_rate_o is 1 for codes 1 and 2, and fs_pol_o is 1 for codes 0 and 2. After tracker reset, the mode equals the speed-select setting, with automatic mapped to full-speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low tracker reset |
| dp_i | input | 1 | D+ wire, asynchronous |
| dm_i | input | 1 | D- wire, asynchronous |
| speed_sel_i | input | 2 | 0/3 automatic, 1 forced full-speed, 2 forced low-speed |
| preamble_i | input | 1 | Preamble seen by the packet layer |
| sym_o | output | 2 | Line symbol: J=0, K=1, SE0=2, SE1=3 |
| speed_o | output | 2 | Mode: 0 full-speed, 1 low-speed, 2 preamble mode |
| ls_rate_o | output | 1 | Low bit rate in use |
| fs_pol_o | output | 1 | Full-speed polarity in use |
| bus_reset_o | output | 1 | One-cycle bus reset event |
| keep_alive_o | output | 1 | One-cycle keep-alive event |

## Verification
The hardest cases to reach are an SE0 exit and a preamble landing on the same clock edge, and SE0 lengths sitting exactly on the keep-alive and reset limits. The stimulus covers the coincidence by raising preamble_i in the cycle two edges after the wires leave SE0. It covers the limits by holding SE0 for KEEPALIVE and RESET cycle counts and for one cycle more than each. A long randomized section then mixes short and long SE0 holds with random preambles. The behavioural reference follows every clock throughout.

// File: rtl/usb_lt_pkg.sv
package usb_lt_pkg;

  typedef enum logic [1:0] {
    SYM_J   = 2'd0,
    SYM_K   = 2'd1,
    SYM_SE0 = 2'd2,
    SYM_SE1 = 2'd3
  } line_sym_e;

  typedef enum logic [1:0] {
    MODE_FS   = 2'd0,
    MODE_LS   = 2'd1,
    MODE_LSRP = 2'd2
  } bus_mode_e;

  localparam logic [1:0] SEL_FS = 2'd1;
  localparam logic [1:0] SEL_LS = 2'd2;

  function automatic bus_mode_e sel_to_mode(input logic [1:0] sel);
    return (sel == SEL_LS) ? MODE_LS : MODE_FS;
  endfunction

  function automatic logic sel_is_auto(input logic [1:0] sel);
    return (sel != SEL_FS) && (sel != SEL_LS);
  endfunction

endpackage

// File: rtl/usb_lt_sync.sv
module usb_lt_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         primed
);
  logic [W-1:0]      stage_q [STAGES];
  logic [STAGES-1:0] fill_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      fill_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      fill_q <= {fill_q[STAGES-2:0], 1'b1};
    end
  end

  assign q      = stage_q[STAGES-1];
  assign primed = fill_q[STAGES-1];

endmodule

// File: rtl/usb_lt_decode.sv
module usb_lt_decode
  import usb_lt_pkg::*;
(
  input  logic [1:0] pins,     // {D+, D-}
  input  logic       primed,
  input  bus_mode_e  mode,
  output line_sym_e  sym
);
  logic swap_jk;
  assign swap_jk = (mode == MODE_LS);

  always_comb begin
    if (!primed) begin
      sym = SYM_J;
    end else begin
      unique case (pins)
        2'b00:   sym = SYM_SE0;
        2'b11:   sym = SYM_SE1;
        2'b10:   sym = swap_jk ? SYM_K : SYM_J;
        default: sym = swap_jk ? SYM_J : SYM_K;
      endcase
    end
  end

endmodule

// File: rtl/usb_lt_se0_timer.sv
module usb_lt_se0_timer #(
  parameter int RST_CYC = 625,
  parameter int KA_CYC  = 300
) (
  input  logic clk,
  input  logic rst_n,
  input  logic se0,
  input  logic is_ls,
  output logic leave,
  output logic bus_reset,
  output logic keep_alive
);
  localparam int            CW  = $clog2(RST_CYC + 2);
  localparam logic [CW-1:0] SAT = CW'(RST_CYC + 1);
  localparam logic [CW-1:0] RL  = CW'(RST_CYC);
  localparam logic [CW-1:0] KL  = CW'(KA_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!se0)     cnt_q <= '0;
    else if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign leave      = (cnt_q != '0) && !se0;
  assign bus_reset  = leave && (cnt_q > RL);
  assign keep_alive = leave && (cnt_q > KL) && (cnt_q <= RL) && is_ls;

  assert_reset_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !bus_reset);
  assert_ka_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_reset && keep_alive));
  assert_ka_ls_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    keep_alive |-> is_ls);

endmodule

// File: rtl/usb_lt_mode.sv
module usb_lt_mode
  import usb_lt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] sel,
  input  logic [1:0] pins,
  input  logic       leave,
  input  logic       bus_reset,
  input  logic       preamble,
  output bus_mode_e  mode
);
  bus_mode_e mode_q, mode_d, base;
  logic      seeded_q;

  assign mode = seeded_q ? mode_q : sel_to_mode(sel);

  always_comb begin
    base   = bus_reset ? sel_to_mode(sel) : mode;
    mode_d = mode;
    if (leave) begin
      mode_d = base;
      if (sel_is_auto(sel)) begin
        if (pins == 2'b10)      mode_d = MODE_FS;
        else if (pins == 2'b01) mode_d = MODE_LS;
      end
    end else if (preamble) begin
      mode_d = MODE_LSRP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_FS;
      seeded_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      seeded_q <= 1'b1;
    end
  end

  assert_preamble_mode_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (preamble && !leave) |=> (mode == MODE_LSRP));
  assert_mode_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seeded_q && !leave && !preamble) |=> $stable(mode));

endmodule

// File: rtl/usb_line_tracker.sv
module usb_line_tracker
  import usb_lt_pkg::*;
#(
  parameter longint CLK_HZ       = 250_000_000,
  parameter int     RESET_NS     = 2500,
  parameter int     KEEPALIVE_NS = 1200,
  parameter int     SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic [1:0] speed_sel_i,
  input  logic       preamble_i,
  output logic [1:0] sym_o,
  output logic [1:0] speed_o,
  output logic       ls_rate_o,
  output logic       fs_pol_o,
  output logic       bus_reset_o,
  output logic       keep_alive_o
);
  localparam int RST_CYC = int'((CLK_HZ * longint'(RESET_NS)) / 64'd1_000_000_000);
  localparam int KA_CYC  = int'((CLK_HZ * longint'(KEEPALIVE_NS)) / 64'd1_000_000_000);

  logic [1:0] pins;
  logic       primed, se0_seen, leave;
  bus_mode_e  mode;
  line_sym_e  sym;

  usb_lt_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({dp_i, dm_i}), .q(pins), .primed(primed)
  );

  assign se0_seen = primed && (pins == 2'b00);

  usb_lt_decode u_decode (
    .pins(pins), .primed(primed), .mode(mode), .sym(sym)
  );

  usb_lt_se0_timer #(.RST_CYC(RST_CYC), .KA_CYC(KA_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .se0(se0_seen), .is_ls(mode == MODE_LS),
    .leave(leave), .bus_reset(bus_reset_o), .keep_alive(keep_alive_o)
  );

  usb_lt_mode u_mode (
    .clk(clk), .rst_n(rst_n), .sel(speed_sel_i), .pins(pins), .leave(leave),
    .bus_reset(bus_reset_o), .preamble(preamble_i), .mode(mode)
  );

  assign sym_o     = sym;
  assign speed_o   = mode;
  assign ls_rate_o = (mode != MODE_FS);
  assign fs_pol_o  = (mode != MODE_LS);

  assert_se0_agree_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sym == SYM_SE0) == se0_seen);
  assert_event_on_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_o || keep_alive_o) |-> (sym != SYM_SE0));

endmodule

// File: tb/usb_line_tracker_tb.sv
module usb_line_tracker_tb;
  localparam int RST = 625;
  localparam int KA  = 300;

  logic clk = 1'b0, rst_n = 1'b0, dp = 1'b1, dm = 1'b0, pre = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [1:0] sym_o, speed_o;
  logic ls_rate_o, fs_pol_o, bus_reset_o, keep_alive_o;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  usb_line_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm), .speed_sel_i(sel),
    .preamble_i(pre), .sym_o(sym_o), .speed_o(speed_o), .ls_rate_o(ls_rate_o),
    .fs_pol_o(fs_pol_o), .bus_reset_o(bus_reset_o), .keep_alive_o(keep_alive_o)
  );

  // behavioural reference state
  logic [1:0] m_p1, m_p2;
  int m_fill, m_cnt, m_mode;
  bit m_seeded;

  function automatic int selmode(logic [1:0] s);
    return (s == 2'd2) ? 1 : 0;
  endfunction
  function automatic int eff_mode();
    return m_seeded ? m_mode : selmode(sel);
  endfunction
  function automatic bit m_se0();
    return (m_fill >= 2) && (m_p2 == 2'b00);
  endfunction
  function automatic bit m_leave();
    return (m_cnt > 0) && !m_se0();
  endfunction
  function automatic bit m_rst_ev();
    return m_leave() && (m_cnt > RST);
  endfunction
  function automatic bit m_ka_ev();
    return m_leave() && (m_cnt > KA) && (m_cnt <= RST) && (eff_mode() == 1);
  endfunction
  function automatic int m_sym();
    if (m_fill < 2) return 0;
    case (m_p2)
      2'b00: return 2;
      2'b11: return 3;
      2'b10: return (eff_mode() == 1) ? 1 : 0;
      default: return (eff_mode() == 1) ? 0 : 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_p1 = 2'b00; m_p2 = 2'b00; m_fill = 0; m_cnt = 0; m_mode = 0; m_seeded = 0;
    end else begin
      int nm;
      nm = eff_mode();
      if (m_leave()) begin
        nm = m_rst_ev() ? selmode(sel) : eff_mode();
        if (sel != 2'd1 && sel != 2'd2) begin
          if (m_p2 == 2'b10) nm = 0;
          else if (m_p2 == 2'b01) nm = 1;
        end
      end else if (pre) nm = 2;
      m_mode = nm; m_seeded = 1;
      if (m_se0()) m_cnt = (m_cnt < RST + 1) ? m_cnt + 1 : m_cnt;
      else m_cnt = 0;
      m_p2 = m_p1; m_p1 = {dp, dm};
      if (m_fill < 2) m_fill++;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int em;
      em = eff_mode();
      chk("R1/R2/R3 sym", sym_o, m_sym());
      chk("R11 speed", speed_o, em);
      chk("R11 ls_rate", ls_rate_o, em != 0);
      chk("R11 fs_pol", fs_pol_o, em != 1);
      chk("R7 bus_reset", bus_reset_o, m_rst_ev());
      chk("R8 keep_alive", keep_alive_o, m_ka_ev());
    end
  end

  task automatic drive(logic [1:0] p, int n);
    @(negedge clk); {dp, dm} = p;
    repeat (n - 1) @(negedge clk);
  endtask

  // hold SE0 n cycles, exit into p, then watch the exit cycle
  task automatic se0_then(int n, logic [1:0] p, output bit saw_rst, output bit saw_ka);
    saw_rst = 0; saw_ka = 0;
    drive(2'b00, n);
    drive(p, 1);
    repeat (4) begin
      @(negedge clk);
      saw_rst |= bus_reset_o; saw_ka |= keep_alive_o;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit r, k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4: first cycle after reset shows J, mode FS (R11)
    chk("R4 sym at reset", sym_o, 0);
    chk("R11 speed at reset", speed_o, 0);
    drive(2'b10, 4);
    // R1: FS polarity
    drive(2'b01, 3); chk("R1 K in FS", sym_o, 1);
    drive(2'b11, 3); chk("R3 SE1", sym_o, 3);
    // R5: auto learns low speed
    se0_then(5, 2'b01, r, k);
    chk("R5 learned LS", speed_o, 1);
    chk("R2 J in LS", sym_o, 0);
    drive(2'b10, 3); chk("R2 K in LS", sym_o, 1);
    // R9 / R8 at the limits
    se0_then(KA, 2'b01, r, k);   chk("R9 no ka at limit", k, 0);
    se0_then(KA + 1, 2'b01, r, k); chk("R8 ka above limit", k, 1); chk("R8 no rst", r, 0);
    se0_then(RST, 2'b01, r, k);  chk("R8 ka at rst limit", k, 1);
    // R7 reset
    se0_then(RST + 1, 2'b10, r, k); chk("R7 reset seen", r, 1); chk("R7 mode FS", speed_o, 0);
    // R8: no keep-alive in FS
    se0_then(400, 2'b10, r, k); chk("R8 none in FS", k, 0);
    // R10 preamble
    @(negedge clk); pre = 1; @(negedge clk); pre = 0;
    chk("R10 speed", speed_o, 2); chk("R10 ls_rate", ls_rate_o, 1); chk("R10 fs_pol", fs_pol_o, 1);
    drive(2'b10, 3); chk("R1 J in preamble mode", sym_o, 0);
    se0_then(400, 2'b11, r, k); chk("R8 none in preamble mode", k, 0);
    chk("R5 SE1 exit keeps mode", speed_o, 2);
    // R6 forced low speed
    sel = 2'd2;
    se0_then(700, 2'b10, r, k); chk("R6 forced LS after reset", speed_o, 1);
    se0_then(10, 2'b10, r, k);  chk("R6 idle polarity ignored", speed_o, 1);
    // R10: exit beats preamble on the same edge
    sel = 2'd1;
    drive(2'b00, 8);
    @(negedge clk); {dp, dm} = 2'b10;
    @(negedge clk);
    @(negedge clk); pre = 1;
    @(negedge clk); pre = 0;
    chk("R10 exit wins", speed_o, 1);
    // randomized section
    sel = 2'd0;
    for (int i = 0; i < 2500; i++) begin
      int len;
      logic [1:0] p;
      p = 2'($urandom_range(0, 3));
      len = ($urandom_range(0, 15) == 0) ? $urandom_range(250, 700) : $urandom_range(1, 8);
      if ($urandom_range(0, 50) == 0) sel = 2'($urandom_range(0, 3));
      @(negedge clk); {dp, dm} = p; pre = ($urandom_range(0, 20) == 0);
      @(negedge clk); pre = 0;
      repeat (len) @(negedge clk);
    end
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule